// File: doc/BRIEF.md
# Context-Tagged Translation Lookaside Buffer

This block holds a small, fully associative set of recent page translations for a 32-bit virtual address. The upper 20 bits of the address are the virtual page number and the lower 12 bits are the in-page offset. Every entry is tagged with a process context identifier as well as a page number, so several address spaces can share the buffer without being flushed on a context switch. A lookup presents a context, an address and an access type. One cycle later the block reports exactly one outcome: a hit with a 36-bit physical address, a miss that hands the page number to the table walker, or a protection fault.

The table walker loads translations through a separate refill port. Each loaded entry carries a 24-bit frame number, a read permission, a write permission and a modify flag. Software can drop every entry that belongs to one context, or every entry at once, in a single cycle. A write to a clean page is reported as a miss, so the walker can record the modification in memory and then reload the entry.

Top module: `ctlb_top`

## Requirements
- R1: A lookup with `lk_valid` high is answered exactly one clock later with `res_valid` high. On a hit, `res_paddr` is the entry's 24-bit frame number in bits 35:12 and the unchanged address bits 11:0 in bits 11:0.
- R2: A hit needs both the context and the page number (address bits 31:12) to match a valid entry. The same page number under a different context misses.
- R3: On a miss, `res_miss` is high, `res_paddr` is zero and `res_vpn` carries the requested page number.
- R4: On a matching entry, a read without read permission, or a write without write permission, sets `res_fault`, clears `res_hit` and gives a zero `res_paddr`. A fault takes precedence over the clean-page miss of R5.
- R5: A write to a writable entry whose modify flag is clear is reported as a miss. A read of the same entry still hits.
- R6: A refill goes to the lowest-numbered invalid entry. When every entry is valid, it replaces a round-robin victim that starts at entry 0 after reset and advances by one on each such replacement.
- R7: A refill whose context and page number match a resident entry overwrites that entry in place, so later lookups return the new frame and no duplicate entry is created.
- R8: Invalidate-by-context clears, in one cycle, every entry tagged with the given context and leaves all other contexts resident.
- R9: Invalidate-all clears every entry in one cycle.
- R10: A lookup sees the buffer as it stood before any refill or invalidation applied in the same cycle. A refill issued in the same cycle as an invalidation is kept.
- R11: After reset, no entry is valid and `res_valid`, `res_hit`, `res_miss` and `res_fault` are low.
- R12: In a cycle after `lk_valid` was low, `res_valid`, `res_hit`, `res_miss` and `res_fault` are all low. When `res_valid` is high, exactly one of the three outcome flags is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request strobe |
| lk_ctx | input | 8 | Context identifier of the lookup |
| lk_vaddr | input | 32 | Virtual address of the lookup |
| lk_write | input | 1 | 1 = write access, 0 = read access |
| res_valid | output | 1 | Result present (one cycle after request) |
| res_hit | output | 1 | Translation found and access allowed |
| res_miss | output | 1 | No usable translation; walker must act |
| res_fault | output | 1 | Access forbidden by entry permissions |
| res_paddr | output | 36 | Physical address on hit, else zero |
| res_vpn | output | 20 | Page number of the answered request |
| fill_en | input | 1 | Refill strobe from table walker |
| fill_ctx | input | 8 | Context of the refill entry |
| fill_vpn | input | 20 | Page number of the refill entry |
| fill_pfn | input | 24 | Frame number of the refill entry |
| fill_rd_ok | input | 1 | Read permission |
| fill_wr_ok | input | 1 | Write permission |
| fill_dirty | input | 1 | Modify flag |
| inv_ctx_en | input | 1 | Invalidate all entries of `inv_ctx` |
| inv_ctx | input | 8 | Context to invalidate |
| inv_all | input | 1 | Invalidate every entry |

## Verification
A lookup can land in the same cycle as an invalidation or a refill, and a refill can coincide with an invalidation. The bench drives these pairs on one falling edge. A lookup of a resident page together with invalidate-all must still hit, and the next lookup of that page must miss. A lookup of a new page together with its refill must miss, and a repeat lookup must hit. A refill issued alongside invalidate-all is judged by whether a later lookup of the refilled page hits.

// File: rtl/ctlb_pkg.sv
package ctlb_pkg;

    localparam int VA_W  = 32;
    localparam int OFF_W = 12;
    localparam int VPN_W = VA_W - OFF_W;
    localparam int PFN_W = 24;
    localparam int PA_W  = PFN_W + OFF_W;
    localparam int CTX_W = 8;

    typedef struct packed {
        logic             valid;
        logic [CTX_W-1:0] ctx;
        logic [VPN_W-1:0] vpn;
        logic [PFN_W-1:0] pfn;
        logic             rd_ok;
        logic             wr_ok;
        logic             dirty;
    } tlb_entry_t;

    typedef enum logic [1:0] {
        K_HIT   = 2'd0,
        K_MISS  = 2'd1,
        K_FAULT = 2'd2
    } lk_kind_t;

    // Outcome of one access against the selected entry.
    function automatic lk_kind_t classify(input logic found,
                                          input tlb_entry_t e,
                                          input logic is_write);
        lk_kind_t k;
        if (!found)                    k = K_MISS;
        else if (is_write && !e.wr_ok) k = K_FAULT;
        else if (!is_write && !e.rd_ok) k = K_FAULT;
        else if (is_write && !e.dirty) k = K_MISS;
        else                           k = K_HIT;
        return k;
    endfunction

endpackage

// File: rtl/ctlb_match.sv
module ctlb_match
    import ctlb_pkg::*;
#(
    parameter int N_ENT = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  tlb_entry_t [N_ENT-1:0]   ents,
    input  logic [CTX_W-1:0]         ctx,
    input  logic [VPN_W-1:0]         vpn,
    output logic [N_ENT-1:0]         hits
);

    for (genvar i = 0; i < N_ENT; i++) begin : g_cmp
        assign hits[i] = ents[i].valid && (ents[i].ctx == ctx) && (ents[i].vpn == vpn);
    end

    // R7: refills update in place, so at most one entry carries any tag
    p_unique_tag_r7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hits));

endmodule

// File: rtl/ctlb_victim.sv
module ctlb_victim
    import ctlb_pkg::*;
#(
    parameter int N_ENT = 16,
    localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_ENT-1:0]   vld,
    input  logic               fill_en,
    input  logic [N_ENT-1:0]   same,
    output logic [IDX_W-1:0]   idx
);

    logic [IDX_W-1:0] rr_q;
    logic [IDX_W-1:0] same_idx;
    logic [IDX_W-1:0] free_idx;
    logic             any_free;
    logic             replace;

    always_comb begin
        same_idx = '0;
        for (int i = 0; i < N_ENT; i++)
            if (same[i]) same_idx = same_idx | IDX_W'(i);
    end

    always_comb begin
        free_idx = '0;
        any_free = 1'b0;
        for (int i = N_ENT - 1; i >= 0; i--)
            if (!vld[i]) begin
                free_idx = IDX_W'(i);
                any_free = 1'b1;
            end
    end

    assign replace = fill_en && !(|same) && !any_free;

    always_comb begin
        if (|same)         idx = same_idx;
        else if (any_free) idx = free_idx;
        else               idx = rr_q;
    end

    always_ff @(posedge clk) begin
        if (rst)
            rr_q <= '0;
        else if (replace)
            rr_q <= (rr_q == IDX_W'(N_ENT - 1)) ? '0 : rr_q + 1'b1;
    end

    // R6: with room available, a new tag never lands on a live entry
    p_free_slot_r6: assert property (@(posedge clk) disable iff (rst)
        fill_en && !(|same) && !(&vld) |-> !vld[idx]);

endmodule

// File: rtl/ctlb_store.sv
module ctlb_store
    import ctlb_pkg::*;
#(
    parameter int N_ENT = 16,
    localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     fill_en,
    input  logic [IDX_W-1:0]         fill_idx,
    input  tlb_entry_t               fill_data,
    input  logic                     inv_all,
    input  logic                     inv_ctx_en,
    input  logic [CTX_W-1:0]         inv_ctx,
    output tlb_entry_t [N_ENT-1:0]   ents,
    output logic [N_ENT-1:0]         vld
);

    tlb_entry_t mem_q [N_ENT];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N_ENT; i++) mem_q[i] <= '0;
        end else begin
            for (int i = 0; i < N_ENT; i++) begin
                if (inv_all || (inv_ctx_en && mem_q[i].ctx == inv_ctx))
                    mem_q[i].valid <= 1'b0;
                // a refill lands after the invalidation of the same cycle
                if (fill_en && fill_idx == IDX_W'(i))
                    mem_q[i] <= fill_data;
            end
        end
    end

    for (genvar i = 0; i < N_ENT; i++) begin : g_out
        assign ents[i] = mem_q[i];
        assign vld[i]  = mem_q[i].valid;
    end

    // R9: a flush without a concurrent refill empties the buffer
    p_flush_all_r9: assert property (@(posedge clk) disable iff (rst)
        inv_all && !fill_en |=> (vld == '0));

    // R10: a refill issued together with a flush survives
    p_fill_kept_r10: assert property (@(posedge clk) disable iff (rst)
        fill_en && inv_all |=> ($countones(vld) == 1));

endmodule

// File: rtl/ctlb_top.sv
module ctlb_top
    import ctlb_pkg::*;
#(
    parameter int N_ENT = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               lk_valid,
    input  logic [7:0]         lk_ctx,
    input  logic [31:0]        lk_vaddr,
    input  logic               lk_write,
    output logic               res_valid,
    output logic               res_hit,
    output logic               res_miss,
    output logic               res_fault,
    output logic [35:0]        res_paddr,
    output logic [19:0]        res_vpn,
    input  logic               fill_en,
    input  logic [7:0]         fill_ctx,
    input  logic [19:0]        fill_vpn,
    input  logic [23:0]        fill_pfn,
    input  logic               fill_rd_ok,
    input  logic               fill_wr_ok,
    input  logic               fill_dirty,
    input  logic               inv_ctx_en,
    input  logic [7:0]         inv_ctx,
    input  logic               inv_all
);

    localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1;

    tlb_entry_t [N_ENT-1:0] ents;
    logic [N_ENT-1:0]       vld;
    logic [N_ENT-1:0]       lk_hits;
    logic [N_ENT-1:0]       fill_hits;
    logic [IDX_W-1:0]       fill_idx;
    logic [VPN_W-1:0]       lk_vpn;
    tlb_entry_t             fill_data;
    tlb_entry_t             sel;
    lk_kind_t               kind;

    assign lk_vpn = lk_vaddr[VA_W-1:OFF_W];

    assign fill_data = '{valid: 1'b1, ctx: fill_ctx, vpn: fill_vpn, pfn: fill_pfn,
                         rd_ok: fill_rd_ok, wr_ok: fill_wr_ok, dirty: fill_dirty};

    ctlb_match #(.N_ENT(N_ENT)) u_lk_match (
        .clk(clk), .rst(rst), .ents(ents), .ctx(lk_ctx), .vpn(lk_vpn), .hits(lk_hits)
    );

    ctlb_match #(.N_ENT(N_ENT)) u_fill_match (
        .clk(clk), .rst(rst), .ents(ents), .ctx(fill_ctx), .vpn(fill_vpn), .hits(fill_hits)
    );

    ctlb_victim #(.N_ENT(N_ENT)) u_victim (
        .clk(clk), .rst(rst), .vld(vld), .fill_en(fill_en), .same(fill_hits), .idx(fill_idx)
    );

    ctlb_store #(.N_ENT(N_ENT)) u_store (
        .clk(clk), .rst(rst), .fill_en(fill_en), .fill_idx(fill_idx), .fill_data(fill_data),
        .inv_all(inv_all), .inv_ctx_en(inv_ctx_en), .inv_ctx(inv_ctx), .ents(ents), .vld(vld)
    );

    // one-hot select: OR of the matching entry
    always_comb begin
        sel = '0;
        for (int i = 0; i < N_ENT; i++)
            if (lk_hits[i]) sel = tlb_entry_t'(sel | ents[i]);
    end

    assign kind = classify(|lk_hits, sel, lk_write);

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            res_hit   <= 1'b0;
            res_miss  <= 1'b0;
            res_fault <= 1'b0;
            res_paddr <= '0;
            res_vpn   <= '0;
        end else begin
            res_valid <= lk_valid;
            res_hit   <= lk_valid && (kind == K_HIT);
            res_miss  <= lk_valid && (kind == K_MISS);
            res_fault <= lk_valid && (kind == K_FAULT);
            res_paddr <= (lk_valid && kind == K_HIT) ? {sel.pfn, lk_vaddr[OFF_W-1:0]} : '0;
            res_vpn   <= lk_valid ? lk_vpn : '0;
        end
    end

    // R1: every request is answered on the next edge
    p_latency_r1: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> res_valid);

    // R1: the in-page offset passes through unchanged
    p_offset_r1: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> (!res_hit || res_paddr[OFF_W-1:0] == $past(lk_vaddr[OFF_W-1:0])));

    // R3 / R4: no address leaves the block without a hit
    p_no_addr_r3: assert property (@(posedge clk) disable iff (rst)
        (res_miss || res_fault) |-> (res_paddr == '0));

    // R12: exactly one outcome per answered request
    p_one_kind_r12: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> ($countones({res_hit, res_miss, res_fault}) == 1));

    // R12: quiet outputs when nothing was asked
    p_idle_r12: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |=> !(res_valid || res_hit || res_miss || res_fault));

endmodule

// File: tb/ctlb_top_tb.sv
module ctlb_top_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        lk_valid;
    logic [7:0]  lk_ctx;
    logic [31:0] lk_vaddr;
    logic        lk_write;
    logic        res_valid, res_hit, res_miss, res_fault;
    logic [35:0] res_paddr;
    logic [19:0] res_vpn;
    logic        fill_en;
    logic [7:0]  fill_ctx;
    logic [19:0] fill_vpn;
    logic [23:0] fill_pfn;
    logic        fill_rd_ok, fill_wr_ok, fill_dirty;
    logic        inv_ctx_en;
    logic [7:0]  inv_ctx;
    logic        inv_all;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ctlb_top u_dut (
        .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_ctx(lk_ctx), .lk_vaddr(lk_vaddr),
        .lk_write(lk_write), .res_valid(res_valid), .res_hit(res_hit), .res_miss(res_miss),
        .res_fault(res_fault), .res_paddr(res_paddr), .res_vpn(res_vpn), .fill_en(fill_en),
        .fill_ctx(fill_ctx), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn), .fill_rd_ok(fill_rd_ok),
        .fill_wr_ok(fill_wr_ok), .fill_dirty(fill_dirty), .inv_ctx_en(inv_ctx_en),
        .inv_ctx(inv_ctx), .inv_all(inv_all)
    );

    // expected kind: 0 hit, 1 miss, 2 fault
    typedef struct packed {
        logic [7:0]  ctx;
        logic [31:0] va;
        logic        wr;
        logic [1:0]  kind;
        logic [23:0] pfn;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VEC [NV] = '{
        '{8'h01, 32'h0001_0123, 1'b0, 2'd0, 24'hABCDE0},  // R1 read hit
        '{8'h02, 32'h0001_0FFF, 1'b1, 2'd0, 24'h111111},  // R1 R2 write hit other ctx
        '{8'h03, 32'h0001_0000, 1'b0, 2'd1, 24'h000000},  // R2 ctx mismatch
        '{8'h01, 32'h0002_0456, 1'b0, 2'd0, 24'h222222},  // R1 read-only page read
        '{8'h01, 32'h0002_0456, 1'b1, 2'd2, 24'h000000},  // R4 write to read-only
        '{8'h01, 32'h0003_0001, 1'b0, 2'd0, 24'h333333},  // R5 clean page read
        '{8'h01, 32'h0003_0001, 1'b1, 2'd1, 24'h000000},  // R5 clean page write
        '{8'h03, 32'hFFFF_FABC, 1'b0, 2'd2, 24'h000000},  // R4 read without permission
        '{8'h03, 32'hFFFF_FABC, 1'b1, 2'd0, 24'hFFFFFF},  // R1 top page write
        '{8'h01, 32'h0004_0000, 1'b0, 2'd1, 24'h000000}   // R3 plain miss
    };

    function automatic logic [1:0] kind_now();
        if (res_hit && !res_miss && !res_fault)  return 2'd0;
        if (res_miss && !res_hit && !res_fault)  return 2'd1;
        if (res_fault && !res_hit && !res_miss)  return 2'd2;
        return 2'd3;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        lk_valid = 0; lk_ctx = 0; lk_vaddr = 0; lk_write = 0;
        fill_en = 0; fill_ctx = 0; fill_vpn = 0; fill_pfn = 0;
        fill_rd_ok = 0; fill_wr_ok = 0; fill_dirty = 0;
        inv_ctx_en = 0; inv_ctx = 0; inv_all = 0;
    endtask

    task automatic set_fill(input logic [7:0] c, input logic [19:0] v, input logic [23:0] p,
                            input logic r, input logic w, input logic d);
        fill_en = 1; fill_ctx = c; fill_vpn = v; fill_pfn = p;
        fill_rd_ok = r; fill_wr_ok = w; fill_dirty = d;
    endtask

    task automatic set_lookup(input logic [7:0] c, input logic [31:0] va, input logic wr);
        lk_valid = 1; lk_ctx = c; lk_vaddr = va; lk_write = wr;
    endtask

    task automatic fill(input logic [7:0] c, input logic [19:0] v, input logic [23:0] p,
                        input logic r, input logic w, input logic d);
        @(negedge clk);
        idle_inputs();
        set_fill(c, v, p, r, w, d);
        @(negedge clk);
        idle_inputs();
    endtask

    // issues a lookup and checks the result one edge later
    task automatic look(input string req, input logic [7:0] c, input logic [31:0] va,
                        input logic wr, input logic [1:0] k, input logic [23:0] p);
        @(negedge clk);
        idle_inputs();
        set_lookup(c, va, wr);
        @(negedge clk);
        idle_inputs();
        check(req, {63'd0, res_valid}, 64'd1);
        check(req, {62'd0, kind_now()}, {62'd0, k});
        check(req, {28'd0, res_paddr}, (k == 2'd0) ? {28'd0, p, va[11:0]} : 64'd0);
        if (k == 2'd1) check(req, {44'd0, res_vpn}, {44'd0, va[31:12]});
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        idle_inputs();
        rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R11: reset state
        check("R11", {60'd0, res_valid, res_hit, res_miss, res_fault}, 64'd0);
        look("R11", 8'h01, 32'h0001_0123, 1'b0, 2'd1, 24'h0);
        @(negedge clk);
        // R12: no request, no outcome
        check("R12", {60'd0, res_valid, res_hit, res_miss, res_fault}, 64'd0);

        fill(8'h01, 20'h00010, 24'hABCDE0, 1, 1, 1);
        fill(8'h02, 20'h00010, 24'h111111, 1, 1, 1);
        fill(8'h01, 20'h00020, 24'h222222, 1, 0, 0);
        fill(8'h01, 20'h00030, 24'h333333, 1, 1, 0);
        fill(8'h03, 20'hFFFFF, 24'hFFFFFF, 0, 1, 1);

        for (int i = 0; i < NV; i++)
            look($sformatf("vector %0d R1-group", i), VEC[i].ctx, VEC[i].va, VEC[i].wr,
                 VEC[i].kind, VEC[i].pfn);

        // R7: refill of resident tag overwrites in place
        fill(8'h01, 20'h00030, 24'h444444, 1, 1, 1);
        look("R7", 8'h01, 32'h0003_0001, 1'b1, 2'd0, 24'h444444);

        // R8: invalidate context 1 only
        @(negedge clk);
        inv_ctx_en = 1; inv_ctx = 8'h01;
        @(negedge clk);
        idle_inputs();
        look("R8", 8'h01, 32'h0001_0123, 1'b0, 2'd1, 24'h0);
        look("R8", 8'h02, 32'h0001_0123, 1'b0, 2'd0, 24'h111111);

        // R10: lookup alongside flush sees old state, then R9 flush result
        @(negedge clk);
        set_lookup(8'h02, 32'h0001_0222, 1'b0);
        inv_all = 1;
        @(negedge clk);
        idle_inputs();
        check("R10", {62'd0, kind_now()}, 64'd0);
        check("R10", {28'd0, res_paddr}, {28'd0, 24'h111111, 12'h222});
        look("R9", 8'h02, 32'h0001_0222, 1'b0, 2'd1, 24'h0);
        look("R9", 8'h03, 32'hFFFF_F000, 1'b1, 2'd1, 24'h0);

        // R10: lookup alongside its own refill misses, then hits
        @(negedge clk);
        set_lookup(8'h07, 32'h0007_7010, 1'b0);
        set_fill(8'h07, 20'h00077, 24'h077077, 1, 1, 1);
        @(negedge clk);
        idle_inputs();
        check("R10", {62'd0, kind_now()}, 64'd1);
        look("R10", 8'h07, 32'h0007_7010, 1'b0, 2'd0, 24'h077077);

        // R10: refill concurrent with flush is kept
        @(negedge clk);
        set_fill(8'h08, 20'h00088, 24'h088088, 1, 1, 1);
        inv_all = 1;
        @(negedge clk);
        idle_inputs();
        look("R10", 8'h08, 32'h0008_8004, 1'b0, 2'd0, 24'h088088);
        look("R10", 8'h07, 32'h0007_7010, 1'b0, 2'd1, 24'h0);

        // R6: fill to capacity, then round-robin victims 0 and 1
        @(negedge clk);
        inv_all = 1;
        @(negedge clk);
        idle_inputs();
        for (int i = 0; i < 16; i++)
            fill(8'h05, 20'(i), 24'(32'h100 + i), 1, 1, 1);
        look("R6", 8'h05, 32'h0000_F00C, 1'b0, 2'd0, 24'h10F);
        fill(8'h05, 20'h00100, 24'h0C0FFE, 1, 1, 1);
        look("R6", 8'h05, 32'h0000_0000, 1'b0, 2'd1, 24'h0);
        look("R6", 8'h05, 32'h0000_1000, 1'b0, 2'd0, 24'h101);
        look("R6", 8'h05, 32'h0010_0ABC, 1'b0, 2'd0, 24'h0C0FFE);
        fill(8'h05, 20'h00101, 24'h0BEEF0, 1, 1, 1);
        look("R6", 8'h05, 32'h0000_1000, 1'b0, 2'd1, 24'h0);
        look("R6", 8'h05, 32'h0000_2000, 1'b0, 2'd0, 24'h102);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule